// File: doc/BRIEF.md
# Trigger Sequencer with Sample Delay and Hold-off

This block decides when a waveform playback engine should begin or begin again. It watches an asynchronous trigger pin and a sample-rate clock enable. It sends out a one-cycle start pulse for each accepted event. It supports four playback modes:

- a free-running mode that starts once after reset and pays no attention to the trigger pin;
- a retrigger mode that starts once after reset and restarts on every accepted trigger;
- an armed single mode that waits for one trigger and then keeps playing;
- an armed retrigger mode that waits for the first trigger and then restarts on each accepted one.

Each accepted trigger loads two down-counters that step on the sample enable:

- a start delay of up to 2^16−1 samples;
- a hold-off window of up to 2^26−1 samples, during which further triggers are discarded.

When the symbol clock comes from outside, a qualified trigger is held until the next sample enable and only then used. When the clock is generated internally, every start also raises a phase-restart strobe for the clock generator. A disarm input sends the armed modes back to waiting and cancels any start that is still in its delay.

Top module: `trgseq_top`

## Requirements
- R1: Mode code 2'b00 (free-running) gives exactly one start pulse, on the first clock after reset is released. After that `running` stays 1, and no trigger on `trig_in` produces another start.
- R2: Mode code 2'b01 (retrigger) starts once after reset like R1. It then gives one more start pulse for every accepted trigger.
- R3: Mode code 2'b10 (armed single) keeps `running` at 0 and gives no start after reset. The first accepted trigger gives one start and sets `running`. Later triggers give no further start.
- R4: Mode code 2'b11 (armed retrigger) keeps `running` at 0 until the first accepted trigger. After that, every accepted trigger gives a start pulse.
- R5: `trig_in` passes two synchronizer flops. It counts only as a rising level that stays high for at least two clock cycles, so a one-cycle pulse is dropped. With zero delay, internal clocking and the enable held high, a trigger first sampled high at clock edge k gives `start_pulse` high right after edge k+3.
- R6: A nonzero `delay_cfg` = D moves the start by D asserted sample enables after acceptance: the start follows the edge after the D-th enabled cycle. Triggers that arrive while the delay is counting are ignored.
- R7: Acceptance loads a hold-off of `inhibit_cfg` = N sample enables. A trigger is dropped unless the hold-off has reached zero by its acceptance cycle. With the enable held high, a second trigger first sampled at edge k+N+1 is accepted, and one sampled at edge k+N is dropped.
- R8: With `ext_clk_mode` = 1, a qualified trigger is accepted only in a cycle where `smp_en` is 1, and it is held until then. `clk_restart` never asserts in this case.
- R9: With `ext_clk_mode` = 0, `clk_restart` pulses in the same cycle as each `start_pulse`.
- R10: A `disarm` pulse in mode 2'b10 or 2'b11 clears `running` and cancels a delayed start, after which the block waits for a new trigger. In modes 2'b00 and 2'b01, `disarm` has no effect.
- R11: While `rst` is high, `start_pulse`, `clk_restart` and `running` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger pin |
| smp_en | input | 1 | Sample-rate clock enable; steps delay and hold-off counters |
| ext_clk_mode | input | 1 | 1: symbol clock from outside, 0: internally generated |
| mode | input | 2 | Playback mode code (see R1–R4) |
| delay_cfg | input | DLY_W | Start delay in samples |
| inhibit_cfg | input | INH_W | Hold-off window in samples |
| disarm | input | 1 | Return armed modes to waiting |
| start_pulse | output | 1 | One-cycle start/restart for the playback engine |
| clk_restart | output | 1 | Clock-phase restart strobe (internal clocking only) |
| running | output | 1 | Playback has been started and not disarmed |

## Verification
The bound checker watches several properties on every cycle:

- the restart strobe never appears without a start pulse and never appears under external clocking;
- the delay counter only moves on a sample enable;
- the hold-off counter is never reloaded while it is counting;
- no start comes out while more than one delay sample remains;
- free-running and armed-single modes never start twice;
- a disarm in an armed mode always leaves the block idle.

Some properties need whole scenarios, which the bench builds: exact start latencies under random enable patterns and delays, the one-cycle pulse filter, the accept and drop boundary of the hold-off window, and triggers ignored during a delay. These depend on when triggers arrive relative to the counters, which no single-cycle property captures.

// File: rtl/trgseq_pkg.sv
`timescale 1ns/1ps
package trgseq_pkg;

    typedef enum logic [1:0] {
        MODE_FREE       = 2'b00,
        MODE_RETRIG     = 2'b01,
        MODE_ARM_ONCE   = 2'b10,
        MODE_ARM_RETRIG = 2'b11
    } trg_mode_e;

    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_PLAY = 1'b1
    } play_ph_e;

    typedef struct packed {
        logic auto_go;
        logic accept_now;
        logic dly_fire;
    } fire_src_t;

    function automatic logic mode_is_armed(trg_mode_e m);
        return m == MODE_ARM_ONCE || m == MODE_ARM_RETRIG;
    endfunction

    function automatic logic mode_takes_trig(trg_mode_e m, play_ph_e ph);
        case (m)
            MODE_FREE:       return 1'b0;
            MODE_RETRIG:     return 1'b1;
            MODE_ARM_ONCE:   return ph == PH_WAIT;
            default:         return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/trgseq_sync.sv
`timescale 1ns/1ps
module trgseq_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic edge_ok
);
    localparam int HIST = SYNC_STAGES + 2;

    logic [HIST-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[HIST-2:0], async_in};
    end

    // synchronized level high for two cycles after having been low
    assign edge_ok = shreg[SYNC_STAGES-1] & shreg[SYNC_STAGES] & ~shreg[SYNC_STAGES+1];
endmodule

// File: rtl/trgseq_dcount.sv
`timescale 1ns/1ps
module trgseq_dcount #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)               cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (step && cnt != '0)   cnt <= cnt - W'(1);
    end
endmodule

// File: rtl/trgseq_top.sv
`timescale 1ns/1ps
module trgseq_top
    import trgseq_pkg::*;
#(
    parameter int DLY_W       = 16,
    parameter int INH_W       = 26,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_in,
    input  logic             smp_en,
    input  logic             ext_clk_mode,
    input  logic [1:0]       mode,
    input  logic [DLY_W-1:0] delay_cfg,
    input  logic [INH_W-1:0] inhibit_cfg,
    input  logic             disarm,
    output logic             start_pulse,
    output logic             clk_restart,
    output logic             running
);
    trg_mode_e        mode_e;
    play_ph_e         ph;
    fire_src_t        src;
    logic             edge_ok, pend_q, trig_evt;
    logic             armed, dis_eff, fire;
    logic [DLY_W-1:0] dly_cnt;
    logic [INH_W-1:0] inh_cnt;

    assign mode_e = trg_mode_e'(mode);

    trgseq_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(trig_in), .edge_ok(edge_ok)
    );

    // hold a qualified edge until the next sample enable in external clocking
    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= ext_clk_mode & (edge_ok | pend_q) & ~smp_en;
    end

    always_comb begin
        trig_evt = (edge_ok | pend_q) & (ext_clk_mode ? smp_en : 1'b1);
        armed    = mode_is_armed(mode_e);
        dis_eff  = disarm & armed;
        src.accept_now = trig_evt && inh_cnt == '0 && dly_cnt == '0
                         && mode_takes_trig(mode_e, ph) && !dis_eff;
        src.auto_go    = !armed && ph == PH_WAIT && dly_cnt == '0;
        src.dly_fire   = dly_cnt == DLY_W'(1) && smp_en && !dis_eff;
        fire = src.auto_go | (src.accept_now && delay_cfg == '0) | src.dly_fire;
    end

    trgseq_dcount #(.W(DLY_W)) u_dly (
        .clk(clk), .rst(rst), .clr(dis_eff), .load(src.accept_now),
        .load_val(delay_cfg), .step(smp_en), .cnt(dly_cnt)
    );

    trgseq_dcount #(.W(INH_W)) u_inh (
        .clk(clk), .rst(rst), .clr(1'b0), .load(src.accept_now),
        .load_val(inhibit_cfg), .step(smp_en), .cnt(inh_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph          <= PH_WAIT;
            start_pulse <= 1'b0;
            clk_restart <= 1'b0;
        end else begin
            if (dis_eff)   ph <= PH_WAIT;
            else if (fire) ph <= PH_PLAY;
            start_pulse <= fire;
            clk_restart <= fire & ~ext_clk_mode;
        end
    end

    assign running = ph == PH_PLAY;
endmodule

// File: rtl/trgseq_chk.sv
`timescale 1ns/1ps
module trgseq_chk #(
    parameter int DLY_W = 16,
    parameter int INH_W = 26
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_en,
    input logic             ext_clk_mode,
    input logic [1:0]       mode,
    input logic             disarm,
    input logic             start_pulse,
    input logic             clk_restart,
    input logic             running,
    input logic [DLY_W-1:0] dly_cnt,
    input logic [INH_W-1:0] inh_cnt
);
    AST_RESTART_WITH_START: assert property (@(posedge clk) disable iff (rst)
        clk_restart |-> start_pulse);                                            // R9
    AST_EXT_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        $past(ext_clk_mode) |-> !clk_restart);                                   // R8
    AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $past(dly_cnt > DLY_W'(1)) |-> !start_pulse);                            // R6
    AST_DELAY_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        ($past(dly_cnt != '0) && !$past(smp_en) && !$past(disarm && mode[1]))
        |-> dly_cnt == $past(dly_cnt));                                          // R6
    AST_INHIBIT_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        $past(inh_cnt != '0) |-> inh_cnt <= $past(inh_cnt));                     // R7
    AST_FREE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && $past(mode) == 2'b00 && $past(running)) |-> !start_pulse); // R1
    AST_ARM_ONCE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && $past(mode) == 2'b10 && $past(running)) |-> !start_pulse); // R3
    AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && $past(mode[1]) && $past(disarm)) |-> (!running && !start_pulse)); // R10
endmodule

bind trgseq_top trgseq_chk #(.DLY_W(DLY_W), .INH_W(INH_W)) u_chk (
    .clk(clk), .rst(rst), .smp_en(smp_en), .ext_clk_mode(ext_clk_mode),
    .mode(mode), .disarm(disarm), .start_pulse(start_pulse),
    .clk_restart(clk_restart), .running(running),
    .dly_cnt(dly_cnt), .inh_cnt(inh_cnt)
);

// File: tb/test_trgseq_top.sv
`timescale 1ns/1ps
module test_trgseq_top;
    localparam int DLY_W = 16;
    localparam int INH_W = 26;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_in = 1'b0;
    logic             smp_en = 1'b1;
    logic             ext_clk_mode = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [DLY_W-1:0] delay_cfg = '0;
    logic [INH_W-1:0] inhibit_cfg = '0;
    logic             disarm = 1'b0;
    logic             start_pulse, clk_restart, running;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    trgseq_top #(.DLY_W(DLY_W), .INH_W(INH_W)) i_trgseq_top (
        .clk(clk), .rst(rst), .trig_in(trig_in), .smp_en(smp_en),
        .ext_clk_mode(ext_clk_mode), .mode(mode), .delay_cfg(delay_cfg),
        .inhibit_cfg(inhibit_cfg), .disarm(disarm), .start_pulse(start_pulse),
        .clk_restart(clk_restart), .running(running)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Index of the negedge at which start_pulse is first seen, from the requirements
    function automatic int exp_start(input bit ext, input int d, input bit [63:0] en);
        int m = 3;
        int cnt = 0;
        if (ext) while (!en[m]) m++;
        if (d == 0) return m + 1;
        for (int j = m + 1; j < 64; j++) begin
            if (en[j]) cnt++;
            if (cnt == d) return j + 1;
        end
        return -1;
    endfunction

    int rst_start;

    task automatic do_reset(input logic [1:0] m, input bit ext, input int d, input int n);
        @(negedge clk);
        rst = 1'b1; mode = m; ext_clk_mode = ext;
        delay_cfg = DLY_W'(d); inhibit_cfg = INH_W'(n);
        trig_in = 1'b0; smp_en = 1'b1; disarm = 1'b0;
        @(negedge clk);
        chk("R11 start in reset", int'(start_pulse), 0);
        chk("R11 running in reset", int'(running), 0);
        chk("R11 restart in reset", int'(clk_restart), 0);
        rst = 1'b0;
        @(negedge clk);
        rst_start = int'(start_pulse);
        repeat (3) @(negedge clk);
    endtask

    int first, second, nst, nrs;

    // trigger pulse set at index 0 with width w; optional second at g2; optional disarm at dis_at
    task automatic scen(input bit [63:0] en, input int w, input int g2, input int dis_at);
        first = -1; second = -1; nst = 0; nrs = 0;
        for (int i = 0; i < 64; i++) begin
            trig_in = (i < w) || (g2 >= 0 && i >= g2 && i < g2 + 2);
            smp_en  = en[i];
            disarm  = (i == dis_at);
            @(negedge clk);
            if (start_pulse) begin
                nst++;
                if (first < 0) first = i + 1;
                else if (second < 0) second = i + 1;
            end
            if (clk_restart) nrs++;
        end
        trig_in = 1'b0; smp_en = 1'b1; disarm = 1'b0;
    endtask

    localparam bit [63:0] ALL = '1;

    initial begin
        bit [63:0] en;
        // R1 free-running
        do_reset(2'b00, 1'b0, 0, 0);
        chk("R1 start after reset", rst_start, 1);
        scen(ALL, 2, 20, -1);
        chk("R1 triggers ignored", nst, 0);
        chk("R1 running", int'(running), 1);

        // R2 retrigger
        do_reset(2'b01, 1'b0, 0, 0);
        chk("R2 start after reset", rst_start, 1);
        scen(ALL, 2, 20, -1);
        chk("R2 first restart", first, 4);
        chk("R2 second restart", second, 24);
        chk("R9 restart per start", nrs, nst);

        // R3 armed single
        do_reset(2'b10, 1'b0, 0, 0);
        chk("R3 no start after reset", rst_start, 0);
        chk("R3 waiting", int'(running), 0);
        scen(ALL, 2, 20, -1);
        chk("R3 first start", first, 4);
        chk("R3 later ignored", nst, 1);
        chk("R3 running", int'(running), 1);

        // R4 armed retrigger
        do_reset(2'b11, 1'b0, 0, 0);
        chk("R4 waiting", int'(running), 0);
        scen(ALL, 2, 20, -1);
        chk("R4 first", first, 4);
        chk("R4 second", second, 24);
        chk("R9 restart count", nrs, 2);

        // R5 width filter
        do_reset(2'b11, 1'b0, 0, 0);
        scen(ALL, 1, -1, -1);
        chk("R5 one-cycle pulse dropped", nst, 0);
        scen(ALL, 2, -1, -1);
        chk("R5 two-cycle pulse latency", first, 4);

        // R6 delay and ignore during delay
        do_reset(2'b11, 1'b0, 20, 0);
        scen(ALL, 2, 8, -1);
        chk("R6 delayed start", first, 24);
        chk("R6 trigger during delay ignored", nst, 1);
        scen(ALL, 2, 30, -1);
        chk("R6 trigger after delay", second, 54);

        // R7 hold-off boundary
        do_reset(2'b11, 1'b0, 0, 10);
        scen(ALL, 2, 10, -1);
        chk("R7 inside window dropped", nst, 1);
        repeat (12) @(negedge clk);
        scen(ALL, 2, 11, -1);
        chk("R7 at window end accepted", second, 15);

        // R8 external clocking, gated acceptance
        for (int i = 0; i < 64; i++) en[i] = (i % 4 == 0);
        do_reset(2'b11, 1'b1, 0, 0);
        scen(en, 2, -1, -1);
        chk("R8 accepted on enable", first, 5);
        chk("R8 no restart strobe", nrs, 0);
        do_reset(2'b11, 1'b0, 0, 0);
        scen(en, 2, -1, -1);
        chk("R9 internal not gated", first, 4);
        chk("R9 strobe with start", nrs, 1);

        // R10 disarm
        do_reset(2'b11, 1'b0, 20, 0);
        scen(ALL, 2, -1, 10);
        chk("R10 delayed start cancelled", nst, 0);
        chk("R10 back to waiting", int'(running), 0);
        scen(ALL, 2, -1, -1);
        chk("R10 rearm by trigger", first, 24);
        do_reset(2'b01, 1'b0, 20, 0);
        scen(ALL, 2, -1, 10);
        chk("R10 no effect in retrigger", first, 24);
        chk("R10 still running", int'(running), 1);

        // random: modes, delays, enable patterns, clocking
        void'($urandom(32'h5EED_0042));
        for (int it = 0; it < 24; it++) begin
            logic [1:0] m = 2'($urandom_range(1, 3));
            bit ext = 1'($urandom_range(0, 1));
            int d = $urandom_range(0, 12);
            for (int i = 0; i < 64; i++) en[i] = (i >= 40) || ($urandom_range(0, 2) != 0);
            do_reset(m, ext, d, $urandom_range(0, 30));
            scen(en, 2, -1, -1);
            chk($sformatf("R6 R8 random start m=%0d ext=%0d d=%0d", m, ext, d),
                first, exp_start(ext, d, en));
            chk("R9 random strobe", nrs, ext ? 0 : 1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule